// File: doc/BRIEF.md
# Four-Mode Power Management Sequencer

This block decides which clock domains of a processor subsystem run at any moment. It keeps one of four operating modes: Fullspeed, Standby, Suspend and Hibernate. Hibernate draws the least power. The core raises a one-cycle request when it decodes a standby, suspend or hibernate instruction. A vector of wake-up event lines, an interrupt-pending line and a PLL-lock line bring the block back to Fullspeed.

Each low-power mode has its own set of wake events and its own mask of gated clock domains, so there is no single sleep/wake pair. When the block leaves a mode that stopped the PLL or the bus clocks, it holds the pipeline and bus clocks off until the PLL reports lock. A wake-cause register keeps the index of the event that caused the first wake-up since the last software read.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the block is in Fullspeed with every clock enable high. `mode` reads 0, `clk_en` reads 9'h1FF, `wake_valid` is 0 and `wake_cause` is 0.
- R2: In Fullspeed, a request moves the block to its mode at the next clock edge. The `mode` codes are 1 for Standby, 2 for Suspend and 3 for Hibernate. When several requests arrive together, the deepest mode wins: Hibernate, then Suspend, then Standby.
- R3: `clk_en` bit positions are: 0 pipeline, 1 system bus, 2 PCI, 3 ISA, 4 external bus, 5 interrupt control, 6 PLL, 7 main crystal, 8 low-speed crystal. The mask is 9'h1FF in Fullspeed, 9'h1FE in Standby, 9'h1E0 in Suspend and 9'h100 in Hibernate.
- R4: Standby returns to Fullspeed one edge after `irq_pending` is seen. Wake event lines have no effect in Standby. This wake records cause code 13.
- R5: Suspend wakes on any of event bits 0 to 11. The bits are: 0 reset-switch release, 1 power button, 2 GPIO, 3 card ready, 4 UART modem status, 5 NMI, 6 RTC alarm, 7 long timer 1, 8 long timer 2, 9 pen touch, 10 key press, 11 PWM channel 0 auto-stop. Bit 12 and `irq_pending` have no effect in Suspend.
- R6: Hibernate wakes only on event bit 12 (RTC reset release), bit 1, bit 2 or bit 6. All other bits have no effect.
- R7: After a Suspend or Hibernate wake, the block waits in a relock phase until `pll_lock` is high. During this phase `mode` reads 2 and `clk_en` reads 9'h1E0. One edge after lock is seen, the block is in Fullspeed with `clk_en` 9'h1FF.
- R8: At a wake, if `wake_valid` is low, `wake_cause` captures the lowest-indexed event that is asserted and enabled for the mode, and `wake_valid` rises. While `wake_valid` is high, later wakes leave the cause unchanged. Events seen in Fullspeed record nothing.
- R9: A `cause_rd` pulse clears `wake_valid` and `wake_cause` at the next edge. If a wake occurs in the same cycle as the read, the new cause is captured and `wake_valid` stays high.
- R10: A mode request that arrives outside Fullspeed, including during relock, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_standby | input | 1 | Standby entry request pulse |
| req_suspend | input | 1 | Suspend entry request pulse |
| req_hibernate | input | 1 | Hibernate entry request pulse |
| irq_pending | input | 1 | Any enabled interrupt pending (Standby wake) |
| wake_evt | input | NUM_WAKE | Wake event lines, bit meanings in R5/R6 |
| pll_lock | input | 1 | PLL lock indication |
| cause_rd | input | 1 | Software read of the wake cause, clears it |
| mode | output | 2 | Current mode code |
| clk_en | output | 9 | Per-domain clock enables |
| wake_valid | output | 1 | Wake cause held |
| wake_cause | output | CAUSE_W | Index of first wake event (13 = interrupt) |

## Verification
Each wake source is swept one bit at a time through both Suspend and Hibernate. This separates the two enabled sets: a bit that is accepted in one mode and ignored in the other shows up as a relock in one case and no mode change in the other. Words with many bits set check that the cause encoder picks the lowest enabled index and not simply the lowest asserted bit. The relock phase is held for several cycles with lock low, so a missing lock wait is caught. Requests are also driven during Standby and during relock, and the capture-versus-read ordering of the cause register is exercised.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  localparam int N_DOM = 9;
  localparam int D_PIPE = 0;
  localparam int D_SBUS = 1;
  localparam int D_PCI  = 2;
  localparam int D_ISA  = 3;
  localparam int D_EXT  = 4;
  localparam int D_INTC = 5;
  localparam int D_PLL  = 6;
  localparam int D_XHI  = 7;
  localparam int D_XLO  = 8;

  typedef enum logic [2:0] {
    ST_FULL = 3'd0,
    ST_STBY = 3'd1,
    ST_SUSP = 3'd2,
    ST_HIB  = 3'd3,
    ST_LOCK = 3'd4
  } pwr_state_e;

  localparam logic [1:0] MODE_FULL = 2'd0;
  localparam logic [1:0] MODE_STBY = 2'd1;
  localparam logic [1:0] MODE_SUSP = 2'd2;
  localparam logic [1:0] MODE_HIB  = 2'd3;
endpackage

// File: rtl/pwr_wake_enc.sv
module pwr_wake_enc #(
  parameter int N = 13,
  parameter int W = 4
) (
  input  logic [N-1:0] req,
  output logic         hit,
  output logic [W-1:0] idx
);
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/pwr_clk_map.sv
module pwr_clk_map
  import pwr_pkg::*;
(
  input  pwr_state_e       st,
  output logic [N_DOM-1:0] en
);
  logic on_full, on_bus, on_osc;

  always_comb begin
    on_full = (st == ST_FULL);
    on_bus  = (st == ST_FULL) || (st == ST_STBY);
    on_osc  = (st != ST_HIB);
  end

  genvar g;
  generate
    for (g = 0; g < N_DOM; g++) begin : g_dom
      if (g == D_PIPE) begin : g_pipe
        assign en[g] = on_full;
      end else if (g <= D_EXT) begin : g_bus
        assign en[g] = on_bus;
      end else if (g <= D_XHI) begin : g_osc
        assign en[g] = on_osc;
      end else begin : g_lo
        assign en[g] = 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_pkg::*;
#(
  parameter int              NUM_WAKE  = 13,
  parameter int              CAUSE_W   = 4,
  parameter logic [NUM_WAKE-1:0] SUSP_MASK = 13'h0FFF,
  parameter logic [NUM_WAKE-1:0] HIB_MASK  = 13'h1046
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_standby,
  input  logic                req_suspend,
  input  logic                req_hibernate,
  input  logic                irq_pending,
  input  logic [NUM_WAKE-1:0] wake_evt,
  input  logic                pll_lock,
  output pwr_state_e          state_q,
  output pwr_state_e          state_d,
  output logic                wake_fire,
  output logic [CAUSE_W-1:0]  wake_code
);
  logic               susp_hit, hib_hit;
  logic [CAUSE_W-1:0] susp_idx, hib_idx;

  pwr_wake_enc #(.N(NUM_WAKE), .W(CAUSE_W)) u_enc_susp (
    .req (wake_evt & SUSP_MASK),
    .hit (susp_hit),
    .idx (susp_idx)
  );

  pwr_wake_enc #(.N(NUM_WAKE), .W(CAUSE_W)) u_enc_hib (
    .req (wake_evt & HIB_MASK),
    .hit (hib_hit),
    .idx (hib_idx)
  );

  always_comb begin
    state_d   = state_q;
    wake_fire = 1'b0;
    wake_code = '0;
    case (state_q)
      ST_FULL: begin
        if (req_hibernate)    state_d = ST_HIB;
        else if (req_suspend) state_d = ST_SUSP;
        else if (req_standby) state_d = ST_STBY;
      end
      ST_STBY: begin
        if (irq_pending) begin
          state_d   = ST_FULL;
          wake_fire = 1'b1;
          wake_code = CAUSE_W'(NUM_WAKE);
        end
      end
      ST_SUSP: begin
        if (susp_hit) begin
          state_d   = ST_LOCK;
          wake_fire = 1'b1;
          wake_code = susp_idx;
        end
      end
      ST_HIB: begin
        if (hib_hit) begin
          state_d   = ST_LOCK;
          wake_fire = 1'b1;
          wake_code = hib_idx;
        end
      end
      ST_LOCK: begin
        if (pll_lock) state_d = ST_FULL;
      end
      default: state_d = ST_FULL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FULL;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/pwr_wake_log.sv
module pwr_wake_log #(
  parameter int CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [CAUSE_W-1:0] code,
  input  logic               rd,
  output logic               valid_q,
  output logic [CAUSE_W-1:0] cause_q
);
  logic               valid_d;
  logic [CAUSE_W-1:0] cause_d;
  logic               cap;

  always_comb begin
    cap     = fire && (!valid_q || rd);
    valid_d = valid_q;
    cause_d = cause_q;
    if (cap) begin
      valid_d = 1'b1;
      cause_d = code;
    end else if (rd) begin
      valid_d = 1'b0;
      cause_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cause_q <= '0;
    end else begin
      valid_q <= valid_d;
      cause_q <= cause_d;
    end
  end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_pkg::*;
#(
  parameter int NUM_WAKE = 13,
  parameter logic [NUM_WAKE-1:0] SUSP_MASK = 13'h0FFF,
  parameter logic [NUM_WAKE-1:0] HIB_MASK  = 13'h1046,
  localparam int CAUSE_W = $clog2(NUM_WAKE + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_standby,
  input  logic                req_suspend,
  input  logic                req_hibernate,
  input  logic                irq_pending,
  input  logic [NUM_WAKE-1:0] wake_evt,
  input  logic                pll_lock,
  input  logic                cause_rd,
  output logic [1:0]          mode,
  output logic [8:0]          clk_en,
  output logic                wake_valid,
  output logic [CAUSE_W-1:0]  wake_cause
);
  pwr_state_e         state_q, state_d;
  logic               wake_fire;
  logic [CAUSE_W-1:0] wake_code;
  logic [N_DOM-1:0]   en_d;

  pwr_mode_fsm #(
    .NUM_WAKE (NUM_WAKE),
    .CAUSE_W  (CAUSE_W),
    .SUSP_MASK(SUSP_MASK),
    .HIB_MASK (HIB_MASK)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_standby  (req_standby),
    .req_suspend  (req_suspend),
    .req_hibernate(req_hibernate),
    .irq_pending  (irq_pending),
    .wake_evt     (wake_evt),
    .pll_lock     (pll_lock),
    .state_q      (state_q),
    .state_d      (state_d),
    .wake_fire    (wake_fire),
    .wake_code    (wake_code)
  );

  pwr_clk_map u_map (
    .st (state_d),
    .en (en_d)
  );

  pwr_wake_log #(.CAUSE_W(CAUSE_W)) u_log (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (wake_fire),
    .code   (wake_code),
    .rd     (cause_rd),
    .valid_q(wake_valid),
    .cause_q(wake_cause)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_en <= '1;
    else        clk_en <= en_d;
  end

  always_comb begin
    case (state_q)
      ST_FULL: mode = MODE_FULL;
      ST_STBY: mode = MODE_STBY;
      ST_HIB:  mode = MODE_HIB;
      default: mode = MODE_SUSP;
    endcase
  end
endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk #(
  parameter int NUM_WAKE = 13,
  localparam int CAUSE_W = $clog2(NUM_WAKE + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_pending,
  input logic               pll_lock,
  input logic               cause_rd,
  input logic [1:0]         mode,
  input logic [8:0]         clk_en,
  input logic               wake_valid,
  input logic [CAUSE_W-1:0] wake_cause
);
  AST_PIPE_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en[0] |-> (mode == 2'd0)); // R3

  AST_LOW_XTAL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en[8]); // R3

  AST_HIB_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> (clk_en == 9'h100)); // R3

  AST_HIB_FROM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && $past(mode) != 2'd3) |-> ($past(mode) == 2'd0)); // R10

  AST_STBY_EXIT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd1 && mode == 2'd0) |-> $past(irq_pending)); // R4

  AST_LOCK_BEFORE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd2 && mode == 2'd0) |-> $past(pll_lock)); // R7

  AST_CAUSE_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_valid) |-> ($past(mode) != 2'd0)); // R8

  AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wake_valid) && !$past(cause_rd)) |-> (wake_valid && $stable(wake_cause))); // R8
endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.NUM_WAKE(NUM_WAKE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_pending(irq_pending),
  .pll_lock   (pll_lock),
  .cause_rd   (cause_rd),
  .mode       (mode),
  .clk_en     (clk_en),
  .wake_valid (wake_valid),
  .wake_cause (wake_cause)
);

// File: tb/sim_pwr_mode_seq.sv
`timescale 1ns/1ps
module sim_pwr_mode_seq;
  localparam int NW = 13;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_standby, req_suspend, req_hibernate;
  logic          irq_pending, pll_lock, cause_rd;
  logic [NW-1:0] wake_evt;
  logic [1:0]    mode;
  logic [8:0]    clk_en;
  logic          wake_valid;
  logic [3:0]    wake_cause;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwr_mode_seq u0 (
    .clk(clk), .rst_n(rst_n),
    .req_standby(req_standby), .req_suspend(req_suspend), .req_hibernate(req_hibernate),
    .irq_pending(irq_pending), .wake_evt(wake_evt), .pll_lock(pll_lock),
    .cause_rd(cause_rd), .mode(mode), .clk_en(clk_en),
    .wake_valid(wake_valid), .wake_cause(wake_cause)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic go(int which);
    if (which == 1) req_standby = 1'b1;
    if (which == 2) req_suspend = 1'b1;
    if (which == 3) req_hibernate = 1'b1;
    tick();
    req_standby = 1'b0; req_suspend = 1'b0; req_hibernate = 1'b0;
  endtask

  task automatic sw_read();
    cause_rd = 1'b1;
    tick();
    cause_rd = 1'b0;
  endtask

  function automatic int mask_of(int m);
    case (m)
      0: return 9'h1FF;
      1: return 9'h1FE;
      2: return 9'h1E0;
      default: return 9'h100;
    endcase
  endfunction

  function automatic bit accepts(int m, int i);
    if (m == 2) return (i <= 11);
    return (i == 1 || i == 2 || i == 6 || i == 12);
  endfunction

  initial begin
    rst_n = 1'b0;
    req_standby = 0; req_suspend = 0; req_hibernate = 0;
    irq_pending = 0; pll_lock = 1; cause_rd = 0; wake_evt = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    chk("R1 mode", mode, 0);
    chk("R1 clk_en", clk_en, 9'h1FF);
    chk("R1 valid", wake_valid, 0);
    chk("R1 cause", wake_cause, 0);

    // R8: events in Fullspeed record nothing
    wake_evt = '1; tick(); wake_evt = '0;
    chk("R8 full no capture", wake_valid, 0);
    chk("R8 full stays", mode, 0);

    // R5/R6 sweep of every wake bit through Suspend and Hibernate
    for (int m = 2; m <= 3; m++) begin
      for (int i = 0; i < NW; i++) begin
        bit en;
        en = accepts(m, i);
        go(m);
        chk("R2 entry", mode, m);
        chk("R3 mask", clk_en, mask_of(m));
        wake_evt = NW'(1) << i; tick(); wake_evt = '0;
        chk(m == 2 ? "R5 valid" : "R6 valid", wake_valid, en);
        if (en) chk("R8 cause", wake_cause, i);
        tick();
        chk(m == 2 ? "R5 mode" : "R6 mode", mode, en ? 0 : m);
        if (!en) begin
          wake_evt = NW'(2); tick(); wake_evt = '0; tick();
          chk("R7 exit", mode, 0);
        end
        chk("R7 full mask", clk_en, 9'h1FF);
        sw_read();
        chk("R9 cleared", wake_valid, 0);
        chk("R9 cause zero", wake_cause, 0);
      end
    end

    // R5: irq has no effect in Suspend
    go(2); irq_pending = 1; tick(); irq_pending = 0;
    chk("R5 irq ignored", mode, 2);
    chk("R5 irq no cause", wake_valid, 0);
    // R8: lowest enabled index among several
    wake_evt = 13'h1FF0; tick(); wake_evt = '0; tick();
    chk("R8 susp lowest", wake_cause, 4);
    sw_read();
    go(3); wake_evt = 13'h1FB9; tick(); wake_evt = '0; tick();
    chk("R8 hib lowest enabled", wake_cause, 12);
    sw_read();

    // R4: Standby ignores events, exits on irq with code 13
    go(1);
    chk("R4 stby mode", mode, 1);
    chk("R3 stby mask", clk_en, 9'h1FE);
    wake_evt = '1; tick(); wake_evt = '0;
    chk("R4 events ignored", mode, 1);
    chk("R4 no cause", wake_valid, 0);
    // R10: request in Standby ignored
    go(3);
    chk("R10 stby req ignored", mode, 1);
    irq_pending = 1; tick(); irq_pending = 0;
    chk("R4 wake", mode, 0);
    chk("R4 cause", wake_cause, 13);
    sw_read();

    // R2 priority
    req_standby = 1; req_suspend = 1; req_hibernate = 1; tick();
    req_standby = 0; req_suspend = 0; req_hibernate = 0;
    chk("R2 hib wins", mode, 3);
    wake_evt = NW'(2); tick(); wake_evt = '0; tick(); sw_read();
    req_standby = 1; req_suspend = 1; tick();
    req_standby = 0; req_suspend = 0;
    chk("R2 susp over stby", mode, 2);
    wake_evt = NW'(1); tick(); wake_evt = '0; tick(); sw_read();

    // R7: relock wait, R10 request during relock
    pll_lock = 0;
    go(2);
    wake_evt = NW'(1) << 9; tick(); wake_evt = '0;
    repeat (5) tick();
    chk("R7 wait mode", mode, 2);
    chk("R7 wait mask", clk_en, 9'h1E0);
    go(3);
    chk("R10 relock req ignored", mode, 2);
    pll_lock = 1; tick();
    chk("R7 locked mode", mode, 0);
    chk("R7 locked mask", clk_en, 9'h1FF);
    chk("R8 pen cause", wake_cause, 9);

    // R8 first cause kept across a second wake
    go(3); wake_evt = NW'(1) << 6; tick(); wake_evt = '0; tick();
    chk("R8 first kept", wake_cause, 9);
    chk("R8 still valid", wake_valid, 1);

    // R9 read coinciding with capture
    go(1); irq_pending = 1; cause_rd = 1; tick(); irq_pending = 0; cause_rd = 0;
    chk("R9 capture wins valid", wake_valid, 1);
    chk("R9 capture wins cause", wake_cause, 13);
    sw_read();
    chk("R9 final clear", wake_valid, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule